// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block keeps one pending-request bit for each of 24 interrupt input pins. It turns every pending, unmasked pin into a delivery message. Each pin has a 64-bit redirection entry, and all 24 entries arrive on one flat input bus that the surrounding register logic owns. Pin activity comes in on a single event port. Each event names a pin number and says whether the pin is asserting or deasserting. It can also mark the event as a pulse, meaning set, deliver and clear in one go.

A service pass walks the pins in ascending order at one pin per clock. When a pin is pending and unmasked, the pass presents a message on a valid/ready output. The message carries the destination, destination mode, delivery mode, vector, polarity and trigger mode taken from that pin's entry.

Back-pressure rules:
- While `msg_valid` is high and `msg_ready` is low, the pass stays on the same pin.
- The message is produced on the clock edge where both are high.
- Pins that are not eligible take one clock each and need no handshake.

Two things start a pass: an assert event on a valid pin, and the `tbl_changed` strobe, which the owner of the table raises after editing an entry. A start request that arrives during a pass is remembered, and a new pass begins as soon as the current one ends.

Top module: `irq_route_engine`

## Requirements
- R1: After reset no pin is pending, no pass is running and `msg_valid` is low.
- R2: The message fields come from the pin's entry at these bit positions: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, trigger 15 (1 = level, 0 = edge), mask 16, destination 63:56.
- R3: A pin whose mask bit is set produces no message, and its pending bit is kept until it is unmasked and rescanned.
- R4: A pass visits pins 0 to 23 in ascending order, one pin per clock when not stalled, and produces one message for each pending, unmasked pin.
- R5: On an edge-triggered pin, the pending bit is cleared when its message is produced.
- R6: On a level-triggered pin, the pending bit stays set after delivery, so every later pass delivers it again.
- R7: A deassert event on a level-triggered pin clears its pending bit.
- R8: A deassert event on an edge-triggered pin has no effect.
- R9: While `msg_valid` is high and `msg_ready` is low, the scan holds its pin and the message stays valid and unchanged.
- R10: A pulse assert on a level-triggered pin sets its pending bit, and the bit is cleared once a pass has visited that pin, with at most one message for that pin.
- R11: Events whose pin number is 24 or above change nothing.
- R12: An assert event or a `tbl_changed` strobe starts a pass. If one arrives during a pass, a second pass follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_flat | input | 1536 | 24 redirection entries, entry i at bits 64*i+63 : 64*i |
| tbl_changed | input | 1 | Table was edited; request a pass |
| ev_valid | input | 1 | Pin event present this cycle |
| ev_pin | input | 5 | Pin number of the event |
| ev_assert | input | 1 | 1 = assert, 0 = deassert |
| ev_pulse | input | 1 | Pulse mode for an assert on a level pin |
| msg_valid | output | 1 | Message presented |
| msg_ready | input | 1 | Consumer accepts message |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_deliv | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector |
| msg_polarity | output | 1 | Polarity |
| msg_level | output | 1 | Trigger mode, 1 = level |

## Verification
The bench parks requests behind masked entries and then unmasks them in bulk. This builds many pending pins at once, so a single pass must show strict ascending order and the correct per-pin fields. A following full-unmask rescan tells edge pins (already gone) apart from level pins (delivered again). Directed cases separate level deassert from edge deassert, pulse mode from plain level assert, and out-of-range pin numbers from their low-bit aliases. One case sends an assert during a running pass for a pin the scan has already passed, and it is delivered only if the rescan request was kept. Random ready stalls show that the message is held unchanged.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int ENTRY_W = 64;

  // entry bit positions
  localparam int VEC_LSB  = 0;
  localparam int DLV_LSB  = 8;
  localparam int DMODE_B  = 11;
  localparam int POL_B    = 13;
  localparam int TRIG_B   = 15;
  localparam int MASK_B   = 16;
  localparam int DEST_LSB = 56;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_mode;
    logic [2:0] deliv;
    logic [7:0] vector;
    logic       polarity;
    logic       level;
  } irq_msg_t;

  function automatic irq_msg_t decode_entry(input logic [ENTRY_W-1:0] e);
    irq_msg_t m;
    m.dest      = e[DEST_LSB +: 8];
    m.dest_mode = e[DMODE_B];
    m.deliv     = e[DLV_LSB +: 3];
    m.vector    = e[VEC_LSB +: 8];
    m.polarity  = e[POL_B];
    m.level     = e[TRIG_B];
    return m;
  endfunction

endpackage

// File: rtl/irq_msg_build.sv
module irq_msg_build
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS*ENTRY_W-1:0] tbl_flat,
  input  logic [IDX_W-1:0]            sel_idx,
  output irq_msg_t                    sel_msg,
  output logic [NUM_PINS-1:0]         mask_vec,
  output logic [NUM_PINS-1:0]         level_vec
);

  logic [ENTRY_W-1:0] sel_entry;

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_fld
      assign mask_vec[g]  = tbl_flat[g*ENTRY_W + MASK_B];
      assign level_vec[g] = tbl_flat[g*ENTRY_W + TRIG_B];
    end
  endgenerate

  always_comb begin
    sel_entry = tbl_flat[sel_idx*ENTRY_W +: ENTRY_W];
    sel_msg   = decode_entry(sel_entry);
  end

endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int NUM_PINS = 24,
  parameter int PIN_ID_W = 5,
  localparam int IDX_W = $clog2(NUM_PINS),
  localparam int PW1 = PIN_ID_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  input  logic [PIN_ID_W-1:0] ev_pin,
  input  logic                ev_assert,
  input  logic                ev_pulse,
  input  logic [NUM_PINS-1:0] level_vec,
  input  logic                visit_done,
  input  logic [IDX_W-1:0]    visit_idx,
  input  logic                delivered,
  output logic [NUM_PINS-1:0] pend,
  output logic                pin_kick
);

  logic [NUM_PINS-1:0] pulse_q;
  logic                in_range;

  assign in_range = {1'b0, ev_pin} < PW1'(NUM_PINS);
  assign pin_kick = ev_valid && ev_assert && in_range;

  genvar i;
  generate
    for (i = 0; i < NUM_PINS; i++) begin : g_pin
      logic hit, visit, set_ev, clr_ev, clr_scan;
      assign hit      = ev_valid && (ev_pin == PIN_ID_W'(i));
      assign visit    = visit_done && (visit_idx == IDX_W'(i));
      assign set_ev   = hit && ev_assert;
      assign clr_ev   = hit && !ev_assert && level_vec[i];
      assign clr_scan = visit && ((delivered && !level_vec[i]) || pulse_q[i]);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend[i]    <= 1'b0;
          pulse_q[i] <= 1'b0;
        end else begin
          if (set_ev)                   pend[i] <= 1'b1;
          else if (clr_ev || clr_scan)  pend[i] <= 1'b0;

          if (set_ev)                   pulse_q[i] <= ev_pulse && level_vec[i];
          else if (clr_ev || visit)     pulse_q[i] <= 1'b0;
        end
      end

      // R5
      edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (visit && delivered && !level_vec[i] && !set_ev) |=> !pend[i]);

      // R7
      lvl_deassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !ev_assert && level_vec[i]) |=> !pend[i]);
    end
  endgenerate

endmodule

// File: rtl/irq_scan_ctrl.sv
module irq_scan_ctrl #(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kick,
  input  logic [NUM_PINS-1:0] pend,
  input  logic [NUM_PINS-1:0] mask_vec,
  input  logic                msg_ready,
  output logic                busy,
  output logic [IDX_W-1:0]    idx,
  output logic                visit_done,
  output logic                delivered,
  output logic                msg_valid
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PINS - 1);

  logic rescan_q;
  logic eligible;
  logic at_last;

  assign eligible   = busy && pend[idx] && !mask_vec[idx];
  assign msg_valid  = eligible;
  assign visit_done = busy && (!eligible || msg_ready);
  assign delivered  = eligible && msg_ready;
  assign at_last    = (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      rescan_q <= 1'b0;
    end else if (!busy) begin
      if (kick) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end else if (visit_done && at_last) begin
      idx      <= '0;
      busy     <= rescan_q || kick;
      rescan_q <= 1'b0;
    end else begin
      if (kick)       rescan_q <= 1'b1;
      if (visit_done) idx <= idx + IDX_W'(1);
    end
  end

  // R4
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (visit_done && !at_last) |=> (busy && idx == $past(idx) + IDX_W'(1)));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (busy && $stable(idx)));

  // R12
  rescan_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (visit_done && at_last && rescan_q) |=> (busy && idx == '0));

endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_ID_W = 5,
  localparam int IDX_W = $clog2(NUM_PINS),
  localparam int TBL_W = NUM_PINS * ENTRY_W,
  localparam int PW1 = PIN_ID_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TBL_W-1:0]    tbl_flat,
  input  logic                tbl_changed,
  input  logic                ev_valid,
  input  logic [PIN_ID_W-1:0] ev_pin,
  input  logic                ev_assert,
  input  logic                ev_pulse,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_dest,
  output logic                msg_dest_mode,
  output logic [2:0]          msg_deliv,
  output logic [7:0]          msg_vector,
  output logic                msg_polarity,
  output logic                msg_level
);

  logic [NUM_PINS-1:0] pend, mask_vec, level_vec;
  logic [IDX_W-1:0]    idx;
  logic                busy, visit_done, delivered, pin_kick, kick;
  irq_msg_t            sel_msg;

  assign kick = pin_kick || tbl_changed;

  irq_msg_build #(.NUM_PINS(NUM_PINS)) u_build (
    .tbl_flat  (tbl_flat),
    .sel_idx   (idx),
    .sel_msg   (sel_msg),
    .mask_vec  (mask_vec),
    .level_vec (level_vec)
  );

  irq_req_bank #(.NUM_PINS(NUM_PINS), .PIN_ID_W(PIN_ID_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (ev_valid),
    .ev_pin     (ev_pin),
    .ev_assert  (ev_assert),
    .ev_pulse   (ev_pulse),
    .level_vec  (level_vec),
    .visit_done (visit_done),
    .visit_idx  (idx),
    .delivered  (delivered),
    .pend       (pend),
    .pin_kick   (pin_kick)
  );

  irq_scan_ctrl #(.NUM_PINS(NUM_PINS)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .kick       (kick),
    .pend       (pend),
    .mask_vec   (mask_vec),
    .msg_ready  (msg_ready),
    .busy       (busy),
    .idx        (idx),
    .visit_done (visit_done),
    .delivered  (delivered),
    .msg_valid  (msg_valid)
  );

  assign msg_dest      = sel_msg.dest;
  assign msg_dest_mode = sel_msg.dest_mode;
  assign msg_deliv     = sel_msg.deliv;
  assign msg_vector    = sel_msg.vector;
  assign msg_polarity  = sel_msg.polarity;
  assign msg_level     = sel_msg.level;

  // R11
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ({1'b0, ev_pin} >= PW1'(NUM_PINS)) && !busy) |=> (pend == $past(pend)));

endmodule

// File: tb/irq_route_engine_tb_top.sv
module irq_route_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;
  localparam int EW = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP*EW-1:0] tbl_flat;
  logic            tbl_changed = 1'b0;
  logic            ev_valid = 1'b0;
  logic [4:0]      ev_pin = '0;
  logic            ev_assert = 1'b0;
  logic            ev_pulse = 1'b0;
  logic            msg_valid;
  logic            msg_ready = 1'b1;
  logic [7:0]      msg_dest;
  logic            msg_dest_mode;
  logic [2:0]      msg_deliv;
  logic [7:0]      msg_vector;
  logic            msg_polarity;
  logic            msg_level;

  int checks = 0;
  int failures = 0;
  bit rnd_ready = 1'b0;
  logic [21:0] got[$];
  logic [21:0] exp_q[$];
  bit          prev_stall = 1'b0;
  logic [21:0] prev_fields;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_engine dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_flat(tbl_flat), .tbl_changed(tbl_changed),
    .ev_valid(ev_valid), .ev_pin(ev_pin), .ev_assert(ev_assert), .ev_pulse(ev_pulse),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_dest_mode(msg_dest_mode), .msg_deliv(msg_deliv), .msg_vector(msg_vector),
    .msg_polarity(msg_polarity), .msg_level(msg_level)
  );

  wire [21:0] cur_fields = {msg_dest, msg_dest_mode, msg_deliv, msg_vector, msg_polarity, msg_level};

  function automatic logic [21:0] exp_of(input logic [63:0] e);
    return {e[63:56], e[11], e[10:8], e[7:0], e[13], e[15]};
  endfunction

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dlv, input logic dm,
                                     input logic pol, input logic lvl, input logic msk,
                                     input logic [7:0] dst);
    logic [63:0] e = '0;
    e[7:0] = vec; e[10:8] = dlv; e[11] = dm; e[13] = pol; e[15] = lvl; e[16] = msk; e[63:56] = dst;
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // ready driver
  initial forever begin
    @(posedge clk); #1;
    msg_ready = rnd_ready ? 1'($urandom % 2) : 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) chk(msg_valid && cur_fields == prev_fields, "R9 stall hold", {42'd0, cur_fields}, {42'd0, prev_fields});
      if (msg_valid && msg_ready) got.push_back(cur_fields);
      prev_stall  = msg_valid && !msg_ready;
      prev_fields = cur_fields;
    end else prev_stall = 1'b0;
  end

  task automatic set_entry(input int i, input logic [63:0] e);
    tbl_flat[i*EW +: EW] = e;
  endtask

  function automatic logic [63:0] get_entry(input int i);
    return tbl_flat[i*EW +: EW];
  endfunction

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    for (int i = 0; i < NP; i++) set_entry(i, 64'h1_0000);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    got.delete(); exp_q.delete();
  endtask

  task automatic send_ev(input int pin, input bit asrt, input bit pulse);
    @(posedge clk); #1;
    ev_valid = 1'b1; ev_pin = 5'(pin); ev_assert = asrt; ev_pulse = pulse;
    @(posedge clk); #1;
    ev_valid = 1'b0; ev_pulse = 1'b0;
  endtask

  task automatic rescan();
    @(posedge clk); #1 tbl_changed = 1'b1;
    @(posedge clk); #1 tbl_changed = 1'b0;
  endtask

  task automatic settle();
    repeat (300) @(posedge clk);
  endtask

  task automatic check_msgs(input string tag);
    int n;
    chk(got.size() == exp_q.size(), {tag, " message count"}, 64'(got.size()), 64'(exp_q.size()));
    n = (got.size() < exp_q.size()) ? got.size() : exp_q.size();
    for (int k = 0; k < n; k++)
      chk(got[k] == exp_q[k], {tag, " message fields"}, {42'd0, got[k]}, {42'd0, exp_q[k]});
    got.delete(); exp_q.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] e;
    logic [23:0] p;
    void'($urandom(32'h5EED_1234));
    tbl_flat = '0;

    // R1: reset state
    do_reset();
    @(negedge clk);
    chk(msg_valid == 1'b0, "R1 valid after reset", 64'(msg_valid), 0);
    settle();
    check_msgs("R1 quiet after reset");

    // R3: masked pins stay pending
    send_ev(0, 1, 0); send_ev(5, 1, 0); settle();
    check_msgs("R3 masked silent");
    e = mk(8'h42, 3'd1, 0, 0, 0, 0, 8'h05);
    set_entry(5, e); rescan(); settle();
    exp_q.push_back(exp_of(e));
    check_msgs("R3 unmasked later");

    // R2 / R5: field decode and edge clear
    do_reset();
    e = mk(8'hA5, 3'b101, 1, 1, 0, 0, 8'h3C);
    set_entry(7, e);
    send_ev(7, 1, 0); settle();
    exp_q.push_back(exp_of(e));
    check_msgs("R2 fields");
    rescan(); settle();
    check_msgs("R5 edge cleared");

    // R6 / R7: level stays, deassert clears
    do_reset();
    e = mk(8'h61, 3'd0, 0, 1, 1, 0, 8'h81);
    set_entry(9, e);
    send_ev(9, 1, 0); settle();
    exp_q.push_back(exp_of(e));
    check_msgs("R6 first");
    rescan(); settle();
    exp_q.push_back(exp_of(e));
    check_msgs("R6 redelivered");
    send_ev(9, 0, 0); settle();
    rescan(); settle();
    check_msgs("R7 deassert clears");

    // R8: edge deassert ignored
    do_reset();
    set_entry(3, mk(8'h33, 3'd2, 0, 0, 0, 1, 8'h01));
    send_ev(3, 1, 0); send_ev(3, 0, 0); settle();
    e = mk(8'h33, 3'd2, 0, 0, 0, 0, 8'h01);
    set_entry(3, e); rescan(); settle();
    exp_q.push_back(exp_of(e));
    check_msgs("R8 edge deassert ignored");

    // R10: pulse mode
    do_reset();
    e = mk(8'h77, 3'd4, 1, 0, 1, 0, 8'hF0);
    set_entry(11, e);
    send_ev(11, 1, 1); settle();
    exp_q.push_back(exp_of(e));
    check_msgs("R10 pulse once");
    rescan(); settle();
    check_msgs("R10 pulse cleared");

    // R11: out-of-range pins
    do_reset();
    for (int i = 0; i < NP; i++) set_entry(i, mk(8'(16 + i), 3'd0, 0, 0, 0, 0, 8'(i)));
    send_ev(24, 1, 0); send_ev(25, 1, 0); send_ev(31, 1, 0); settle();
    check_msgs("R11 no message");
    rescan(); settle();
    check_msgs("R11 nothing pending");

    // R12: rescan latched during a pass
    do_reset();
    set_entry(1, mk(8'h11, 3'd0, 0, 0, 0, 0, 8'h01));
    set_entry(2, mk(8'h22, 3'd0, 0, 0, 0, 0, 8'h02));
    send_ev(2, 1, 0);
    repeat (4) @(posedge clk);
    send_ev(1, 1, 0); settle();
    exp_q.push_back(exp_of(get_entry(2)));
    exp_q.push_back(exp_of(get_entry(1)));
    check_msgs("R12 latched rescan");

    // R4 / R9: all pins, ordered, random stalls
    do_reset();
    rnd_ready = 1'b1;
    for (int i = 0; i < NP; i++) send_ev(i, 1, 0);
    settle();
    for (int i = 0; i < NP; i++) begin
      e = mk(8'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 0, 0, 8'($urandom));
      set_entry(i, e);
      exp_q.push_back(exp_of(e));
    end
    rescan(); settle();
    check_msgs("R4 ascending order");

    // random mix
    for (int it = 0; it < 20; it++) begin
      do_reset();
      p = 24'($urandom);
      for (int i = 0; i < NP; i++) if (p[i]) send_ev(i, 1, 0);
      settle();
      check_msgs("R3 random masked");
      for (int i = 0; i < NP; i++) begin
        e = {$urandom(), $urandom()};
        e[16] = ($urandom % 3 == 0);
        set_entry(i, e);
      end
      rescan(); settle();
      for (int i = 0; i < NP; i++) begin
        e = get_entry(i);
        if (p[i] && !e[16]) begin
          exp_q.push_back(exp_of(e));
          if (!e[15]) p[i] = 1'b0;
        end
      end
      check_msgs("R4 random pass");
      for (int i = 0; i < NP; i++) begin
        e = get_entry(i); e[16] = 1'b0; set_entry(i, e);
      end
      rescan(); settle();
      for (int i = 0; i < NP; i++) if (p[i]) exp_q.push_back(exp_of(get_entry(i)));
      check_msgs("R6 random remaining");
    end
    rnd_ready = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule